// File: doc/BRIEF.md
# Bypassable Slack Buffer Bank with Reset Tokens

This block places one single-place buffer stage on each of several dual-rail output channels. Each channel carries one value per four-phase handshake: the sender raises exactly one of two data rails, the receiver lowers its enable, the sender returns both rails low, and the receiver raises its enable again. A stage holds one token at a time. It adds one place of slack to the channel, which is used to match pipeline depths.

Each channel has its own configuration. One bit takes the stage out of the path, so the rails and the enable connect directly between the two sides. Two further bits choose what a stage that is in the path holds when reset is released: nothing, a token of value zero, or a token of value one. Loading a token at reset lets a loop in the circuit start with data already in it. The handshake is modelled with a clock so that the behaviour can be checked cycle by cycle. The configuration must be set before reset is released and must stay constant afterwards.

Top module: `slack_bank`

## Requirements
- R1: With the bypass bit of a channel set, dn_d0/dn_d1 follow up_d0/up_d1, and up_en follows dn_en, with no register in between.
- R2: With the bypass bit set, the token setting of that channel has no effect. After reset the output rails stay low for as long as the upstream rails stay low.
- R3: In buffer mode with no token selected (cfg_tok_en=0), both output rails are low after reset and up_en is high. Upstream values then appear at the output one at a time, in the order they were sent.
- R4: In buffer mode with cfg_tok_en=1 and cfg_tok_val=0, the first value delivered after reset is a zero (dn_d0 high, dn_d1 low). Upstream values follow it in order.
- R5: In buffer mode with cfg_tok_en=1 and cfg_tok_val=1, the first value delivered after reset is a one (dn_d1 high, dn_d0 low). Upstream values follow it in order.
- R6: A token loaded at reset keeps up_en low until the downstream side has lowered dn_en and then raised it again.
- R7: A stage holds at most one token. While it holds one, up_en stays low, and up_en is never high while output data is driven.
- R8: A stage never starts driving an output rail in a cycle that follows a cycle in which dn_en was low. A token it holds waits until dn_en is high.
- R9: The two output rails are never high together. Once output data is driven with dn_en high, it holds until dn_en falls, and up_en is low in the cycle the rails return low.
- R10: The configuration of each channel affects only that channel.
- R11: While reset is held, a channel in buffer mode drives both output rails low and holds up_en low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, is released synchronously inside the block |
| cfg_bypass | input | NCH | Per channel: 1 takes the stage out of the path |
| cfg_tok_en | input | NCH | Per channel: 1 loads a token at reset |
| cfg_tok_val | input | NCH | Per channel: value of the token loaded at reset |
| up_d0 | input | NCH | Upstream rail for the value zero |
| up_d1 | input | NCH | Upstream rail for the value one |
| up_en | output | NCH | Enable returned to the upstream sender |
| dn_d0 | output | NCH | Downstream rail for the value zero |
| dn_d1 | output | NCH | Downstream rail for the value one |
| dn_en | input | NCH | Enable from the downstream receiver |

## Verification
The assertions cover the properties that must hold in every cycle: the two output rails are never high together, output data never starts after a cycle with dn_en low, driven data holds while dn_en is high, and up_en is never high while the stage drives its output or while its rails return low. Other behaviour can only be shown by the bench scenarios. These cover the order of values after each of the three reset settings, the loaded token holding up_en low until a full downstream handshake has completed, and the direct connection of rails and enable in bypass, where the token setting has no effect. Two mixed configurations show that each channel's reset token depends only on its own configuration bits.

// File: rtl/slack_pkg.sv
package slack_pkg;
  // Per-stage handshake position
  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,  // just out of reset, configuration not yet applied
    ST_EMPTY = 3'd1,  // no token, ready to accept from upstream
    ST_FULL  = 3'd2,  // token held, waiting for the downstream enable
    ST_SEND  = 3'd3,  // token driven on the output rails
    ST_DRAIN = 3'd4   // rails returned low, waiting for the enable to rise
  } stg_state_e;
endpackage

// File: rtl/slack_rst_sync.sv
module slack_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/slack_stage.sv
module slack_stage
  import slack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_bypass,
  input  logic cfg_tok_en,
  input  logic cfg_tok_val,
  input  logic in_d0,
  input  logic in_d1,
  output logic in_en,
  output logic out_d0,
  output logic out_d1,
  input  logic out_en
);
  stg_state_e st_q, st_nxt;
  logic       val_q, val_nxt;
  logic       pend_q, pend_nxt;   // upstream data not yet returned to neutral
  logic       take;
  logic       st_ce, val_ce, pend_ce;

  assign take = (st_q == ST_EMPTY) && !pend_q && (in_d0 ^ in_d1);

  always_comb begin
    st_nxt  = st_q;
    val_nxt = val_q;
    case (st_q)
      ST_INIT: begin
        if (!cfg_bypass) begin
          st_nxt  = cfg_tok_en ? ST_FULL : ST_EMPTY;
          val_nxt = cfg_tok_val;
        end
      end
      ST_EMPTY: begin
        if (take) begin
          st_nxt  = ST_FULL;
          val_nxt = in_d1;
        end
      end
      ST_FULL:  if (out_en)  st_nxt = ST_SEND;
      ST_SEND:  if (!out_en) st_nxt = ST_DRAIN;
      ST_DRAIN: if (out_en)  st_nxt = ST_EMPTY;
      default:  st_nxt = ST_INIT;
    endcase
  end

  always_comb begin
    pend_nxt = pend_q;
    if (take)                 pend_nxt = 1'b1;
    else if (!in_d0 && !in_d1) pend_nxt = 1'b0;
  end

  assign st_ce   = (st_nxt != st_q);
  assign val_ce  = take || (st_q == ST_INIT);
  assign pend_ce = (pend_nxt != pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_INIT;
    else if (st_ce) st_q <= st_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      val_q <= 1'b0;
    else if (val_ce) val_q <= val_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_ce) pend_q <= pend_nxt;
  end

  assign in_en  = (st_q == ST_EMPTY) && !pend_q;
  assign out_d0 = (st_q == ST_SEND) && !val_q;
  assign out_d1 = (st_q == ST_SEND) &&  val_q;
endmodule

// File: rtl/slack_bypass_mux.sv
module slack_bypass_mux (
  input  logic byp,
  input  logic up_d0,
  input  logic up_d1,
  input  logic stg_d0,
  input  logic stg_d1,
  input  logic stg_en,
  input  logic dn_en,
  output logic dn_d0,
  output logic dn_d1,
  output logic up_en
);
  always_comb begin
    if (byp) begin
      dn_d0 = up_d0;
      dn_d1 = up_d1;
      up_en = dn_en;
    end else begin
      dn_d0 = stg_d0;
      dn_d1 = stg_d1;
      up_en = stg_en;
    end
  end
endmodule

// File: rtl/slack_bank.sv
module slack_bank #(
  parameter int NCH        = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] cfg_bypass,
  input  logic [NCH-1:0] cfg_tok_en,
  input  logic [NCH-1:0] cfg_tok_val,
  input  logic [NCH-1:0] up_d0,
  input  logic [NCH-1:0] up_d1,
  output logic [NCH-1:0] up_en,
  output logic [NCH-1:0] dn_d0,
  output logic [NCH-1:0] dn_d1,
  input  logic [NCH-1:0] dn_en
);
  logic rst_int_n;

  slack_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic s_d0, s_d1, s_en;

    slack_stage u_stage (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .cfg_bypass  (cfg_bypass[g]),
      .cfg_tok_en  (cfg_tok_en[g]),
      .cfg_tok_val (cfg_tok_val[g]),
      .in_d0       (up_d0[g]),
      .in_d1       (up_d1[g]),
      .in_en       (s_en),
      .out_d0      (s_d0),
      .out_d1      (s_d1),
      .out_en      (dn_en[g])
    );

    slack_bypass_mux u_mux (
      .byp    (cfg_bypass[g]),
      .up_d0  (up_d0[g]),
      .up_d1  (up_d1[g]),
      .stg_d0 (s_d0),
      .stg_d1 (s_d1),
      .stg_en (s_en),
      .dn_en  (dn_en[g]),
      .dn_d0  (dn_d0[g]),
      .dn_d1  (dn_d1[g]),
      .up_en  (up_en[g])
    );
  end
endmodule

// File: rtl/slack_bank_chk.sv
module slack_bank_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] cfg_bypass,
  input logic [NCH-1:0] up_en,
  input logic [NCH-1:0] dn_d0,
  input logic [NCH-1:0] dn_d1,
  input logic [NCH-1:0] dn_en
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R9: the two output rails are never high together
    a_r9_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({dn_d0[g], dn_d1[g]}) <= 1);

    // R8: output data only starts after a cycle with the enable high
    a_r8_start_after_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bypass[g] && $rose(dn_d0[g] | dn_d1[g])) |-> $past(dn_en[g]));

    // R9: driven data holds while the enable stays high
    a_r9_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bypass[g] && (dn_d0[g] | dn_d1[g]) && dn_en[g])
        |=> (dn_d0[g] == $past(dn_d0[g]) && dn_d1[g] == $past(dn_d1[g])));

    // R7: never ready upstream while data is driven downstream
    a_r7_single_token: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bypass[g] && up_en[g]) |-> !(dn_d0[g] | dn_d1[g]));

    // R9: up_en stays low in the cycle the output rails return low
    a_r9_no_ready_on_return: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_bypass[g] && $fell(dn_d0[g] | dn_d1[g])) |-> !up_en[g]);
  end
endmodule

bind slack_bank slack_bank_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_bypass (cfg_bypass),
  .up_en      (up_en),
  .dn_d0      (dn_d0),
  .dn_d1      (dn_d1),
  .dn_en      (dn_en)
);

// File: tb/sim_slack_bank.sv
module sim_slack_bank;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst_n;
  logic [NCH-1:0] byp, tok_en, tok_val;
  logic [NCH-1:0] up_d0, up_d1, up_en, dn_d0, dn_d1, dn_en;
  int checks = 0;
  int errors = 0;

  slack_bank #(.NCH(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_bypass(byp), .cfg_tok_en(tok_en),
    .cfg_tok_val(tok_val), .up_d0(up_d0), .up_d1(up_d1), .up_en(up_en),
    .dn_d0(dn_d0), .dn_d1(dn_d1), .dn_en(dn_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R11 checked while reset is held
  task automatic do_reset(input logic [NCH-1:0] b, input logic [NCH-1:0] te,
                          input logic [NCH-1:0] tv);
    @(negedge clk);
    rst_n = 1'b0; byp = b; tok_en = te; tok_val = tv;
    up_d0 = '0; up_d1 = '0; dn_en = '1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      if (!b[c]) begin
        chk("R11 up_en low in reset", int'(up_en[c]), 0);
        chk("R11 rails low in reset", int'(dn_d0[c] | dn_d1[c]), 0);
      end
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_up(input int c, input logic v, input string req);
    int n;
    n = 0;
    while (!up_en[c] && n < 100) begin @(negedge clk); n++; end
    chk({req, " up_en before send"}, int'(up_en[c]), 1);
    if (v) up_d1[c] = 1'b1; else up_d0[c] = 1'b1;
    @(negedge clk);
    n = 0;
    while (up_en[c] && n < 100) begin @(negedge clk); n++; end
    chk({req, " up_en dropped after send"}, int'(up_en[c]), 0);
    up_d0[c] = 1'b0; up_d1[c] = 1'b0;
    @(negedge clk);
  endtask

  // value code: 0 = rail zero, 1 = rail one, 2 = no rail, 3 = both rails
  task automatic recv_dn(input int c, input int exp, input string req);
    int n;
    int act;
    n = 0;
    while (!(dn_d0[c] | dn_d1[c]) && n < 100) begin @(negedge clk); n++; end
    act = (dn_d0[c] && dn_d1[c]) ? 3 : dn_d0[c] ? 0 : dn_d1[c] ? 1 : 2;
    chk(req, act, exp);
    dn_en[c] = 1'b0;
    n = 0;
    @(negedge clk);
    while ((dn_d0[c] | dn_d1[c]) && n < 100) begin @(negedge clk); n++; end
    chk({req, " rails returned low"}, int'(dn_d0[c] | dn_d1[c]), 0);
    dn_en[c] = 1'b1;
    @(negedge clk);
  endtask

  // Buffer-mode scenario: reset content, order of values, one-token rule, enable gating
  task automatic t_stage(input int c, input logic te, input logic tv);
    logic [4:0] seq;
    string tag;
    seq = 5'b01101;
    tag = te ? (tv ? "R5 token one first" : "R4 token zero first") : "R3 empty after reset";
    if (te) begin
      repeat (3) @(negedge clk);
      chk("R6 up_en low while loaded token waits", int'(up_en[c]), 0);
      recv_dn(c, int'(tv), tag);
      chk("R6 up_en high after token handshake", int'(up_en[c]), 1);
    end else begin
      chk(tag, int'(dn_d0[c] | dn_d1[c]), 0);
      chk("R3 up_en high when empty", int'(up_en[c]), 1);
    end
    for (int i = 0; i < 5; i++) begin
      send_up(c, seq[i], "R3 stream");
      chk("R7 no second accept while full", int'(up_en[c]), 0);
      recv_dn(c, int'(seq[i]), "R3 value order");
    end
    dn_en[c] = 1'b0;
    send_up(c, 1'b0, "R8 stream");
    repeat (4) @(negedge clk);
    chk("R8 no data while dn_en low", int'(dn_d0[c] | dn_d1[c]), 0);
    chk("R7 still full with dn_en low", int'(up_en[c]), 0);
    dn_en[c] = 1'b1;
    recv_dn(c, 0, "R8 data after enable rises");
  endtask

  // Bypass scenario: direct connection, token setting ignored
  task automatic t_bypass(input int c);
    chk("R2 no token appears in bypass", int'(dn_d0[c] | dn_d1[c]), 0);
    chk("R1 enable high passes", int'(up_en[c]), 1);
    up_d1[c] = 1'b1;
    @(negedge clk);
    chk("R1 rail one passes", int'(dn_d1[c]), 1);
    chk("R1 rail zero stays low", int'(dn_d0[c]), 0);
    dn_en[c] = 1'b0;
    @(negedge clk);
    chk("R1 enable low passes", int'(up_en[c]), 0);
    up_d1[c] = 1'b0;
    @(negedge clk);
    chk("R1 rail one returns low", int'(dn_d1[c]), 0);
    dn_en[c] = 1'b1;
    up_d0[c] = 1'b1;
    @(negedge clk);
    chk("R1 rail zero passes", int'(dn_d0[c]), 1);
    chk("R2 rail one unaffected", int'(dn_d1[c]), 0);
    up_d0[c] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; byp = '0; tok_en = '0; tok_val = '0;
    up_d0 = '0; up_d1 = '0; dn_en = '1;

    // Run A: ch0 empty, ch1 token 0, ch2 token 1, ch3 bypass with token 1 set
    do_reset(4'b1000, 4'b1110, 4'b1100);
    chk("R10 rail zero per channel", int'(dn_d0), 4'b0010);
    chk("R10 rail one per channel", int'(dn_d1), 4'b0100);
    t_stage(0, 1'b0, 1'b0);
    t_stage(1, 1'b1, 1'b0);
    t_stage(2, 1'b1, 1'b1);
    t_bypass(3);

    // Run B: ch0 bypass with token 0 set, ch1 token 1, ch2 empty, ch3 token 0
    do_reset(4'b0001, 4'b1011, 4'b0010);
    chk("R10 rail zero per channel", int'(dn_d0), 4'b1000);
    chk("R10 rail one per channel", int'(dn_d1), 4'b0010);
    t_bypass(0);
    t_stage(1, 1'b1, 1'b1);
    t_stage(2, 1'b0, 1'b0);
    t_stage(3, 1'b1, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule